// File: doc/BRIEF.md
# Dual-Mode Logic Analyzer Capture Engine

The block records a 16-channel probe bus into an on-chip sample buffer. After an arm pulse it writes one buffer word per sample into consecutive addresses, starting at zero, until every address has been filled. It then stops and holds the contents for a host to read back. All channels are registered together on the same internal clock edge, so every stored word is one coherent snapshot of the bus.

Two sampling modes share the same capture path. In timing mode a sample is taken on every internal clock cycle, so the buffer records a waveform at the internal clock rate. In state mode the target system's own clock is brought into the internal domain through a synchronizer, and one sample is stored per rising edge of that clock. On readback the host supplies an address. One cycle later the block returns the stored word together with its sample index, which is the position of the sample in the capture sequence. A finished capture is protected: a new arm has no effect until the host has released the buffer.

Top module: `la_capture`

## Requirements
- R1: After reset, `capturing` is 0, `done` is 0 and `rd_valid` is 0.
- R2: An `arm` pulse sampled while the block is idle makes `capturing` read 1 and `done` read 0 on the following cycle.
- R3: In timing mode (`mode_state` = 0), buffer address i holds the value that `probe_in` had at the clock edge i cycles after the edge that sampled `arm`, for i from 0 to DEPTH-1, with all 16 bits taken together.
- R4: In state mode (`mode_state` = 1), one word is stored per rising edge of `ext_clk`. The word for the j-th rising edge after arm goes to address j. It equals `probe_in` as seen at the second internal clock edge at which `ext_clk` reads high. `ext_clk` must stay high and low for at least two internal cycles each.
- R5: In state mode, no word is stored while `ext_clk` is static, so `done` stays 0 and `capturing` stays 1.
- R6: `done` rises, and `capturing` falls, exactly one cycle after the write of address DEPTH-1. In timing mode this is DEPTH cycles after the edge that sampled `arm`, and never earlier.
- R7: Once `done` is 1, later changes on `probe_in` and `ext_clk` leave the buffer contents unchanged.
- R8: If `rd_en` is sampled high while not capturing, then on the next cycle `rd_valid` is 1, `rd_index` equals the sampled `rd_addr`, and `rd_word` equals the word stored at that address.
- R9: A read request sampled while capturing returns `rd_valid` = 0.
- R10: After a capture completes, `arm` has no effect and `done` stays 1 until `host_release` is pulsed. After the release, an `arm` pulse starts a new capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_state | input | 1 | 0 = timing mode, 1 = state mode |
| ext_clk | input | 1 | Target clock, asynchronous to `clk` |
| probe_in | input | CH_W (16) | Probe channels |
| arm | input | 1 | Start-capture pulse |
| host_release | input | 1 | Frees a held buffer so that a new arm is accepted |
| capturing | output | 1 | Capture in progress |
| done | output | 1 | Buffer full, contents held |
| rd_en | input | 1 | Read request |
| rd_addr | input | $clog2(DEPTH) | Read address |
| rd_valid | output | 1 | Read result valid, one cycle after the request |
| rd_index | output | $clog2(DEPTH) | Sample index of the returned word |
| rd_word | output | CH_W (16) | Stored probe word |

## Verification
A wrong write address or a skipped increment shows up on the first readback sweep: a stored word sits at the wrong index, or a value is duplicated. The bench reads every address of a small buffer and compares it against the arithmetic pattern it drove. A wrong fill count moves the rising edge of `done` off its exact cycle, which is checked on the cycle before and the cycle at which it should rise. Faults in the synchronizer or the edge detector store the wrong word or the wrong number of words in state mode. The bench sees these either as a `done` that arrives early or late, or as mismatched words on readback.

// File: rtl/la_cap_pkg.sv
package la_cap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_HOLD = 2'd2
  } cap_state_e;

  typedef enum logic {
    MODE_TIMING = 1'b0,
    MODE_STATE  = 1'b1
  } samp_mode_e;

endpackage

// File: rtl/la_edge_sync.sv
module la_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   prev_q;

  // first stage takes the asynchronous input
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= async_in;
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain_q[SYNC_STAGES-1];
  end

  assign rise_o = chain_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_cap_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_i,
  input  logic          release_i,
  input  logic          sample_en_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic          capturing_o,
  output logic          done_o
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  cap_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          done_q, done_d;
  logic          we;

  // next-state logic
  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    done_d  = done_q;
    we      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (arm_i) begin
          state_d = ST_CAPT;
          addr_d  = '0;
          done_d  = 1'b0;
        end
      end
      ST_CAPT: begin
        if (sample_en_i) begin
          we = 1'b1;
          if (addr_q == LAST_ADDR) begin
            state_d = ST_HOLD;
            done_d  = 1'b1;
          end else begin
            addr_d = AW'(addr_q + 1'b1);
          end
        end
      end
      ST_HOLD: begin
        if (release_i) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      done_q  <= done_d;
    end
  end

  assign we_o        = we;
  assign waddr_o     = addr_q;
  assign capturing_o = (state_q == ST_CAPT);
  assign done_o      = done_q;

  // R6: done only rises right after the final address was written
  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(we_o && (waddr_o == LAST_ADDR)));

  // R6: a full buffer is never still capturing
  p_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !capturing_o);

  // R3: consecutive writes land on consecutive addresses
  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we_o && (waddr_o != LAST_ADDR)) |=> (waddr_o == AW'($past(waddr_o) + 1'b1)));

  // R10: a held buffer stays held until the host releases it
  p_hold_arm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && !release_i) |=> (state_q == ST_HOLD));

endmodule

// File: rtl/la_sample_mem.sv
module la_sample_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);

  logic [W-1:0] mem_q [DEPTH];
  logic [W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/la_capture.sv
module la_capture
  import la_cap_pkg::*;
#(
  parameter int CH_W        = 16,
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_state,
  input  logic            ext_clk,
  input  logic [CH_W-1:0] probe_in,
  input  logic            arm,
  input  logic            host_release,
  output logic            capturing,
  output logic            done,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic            rd_valid,
  output logic [AW-1:0]   rd_index,
  output logic [CH_W-1:0] rd_word
);

  samp_mode_e      mode;
  logic [CH_W-1:0] sample_q;
  logic            ext_rise;
  logic            sample_en;
  logic            we;
  logic [AW-1:0]   waddr;
  logic            rd_accept;
  logic            rd_valid_q;
  logic [AW-1:0]   rd_index_q;

  assign mode = samp_mode_e'(mode_state);

  // all channels share one sampling edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_q <= '0;
    else        sample_q <= probe_in;
  end

  la_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ext_clk),
    .rise_o  (ext_rise)
  );

  always_comb begin
    unique case (mode)
      MODE_STATE:  sample_en = ext_rise;
      default:     sample_en = 1'b1;
    endcase
  end

  la_capture_ctrl #(
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (arm),
    .release_i  (host_release),
    .sample_en_i(sample_en),
    .we_o       (we),
    .waddr_o    (waddr),
    .capturing_o(capturing),
    .done_o     (done)
  );

  assign rd_accept = rd_en & ~capturing;

  la_sample_mem #(
    .W    (CH_W),
    .DEPTH(DEPTH),
    .AW   (AW)
  ) u_mem (
    .clk    (clk),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(sample_q),
    .re_i   (rd_accept),
    .raddr_i(rd_addr),
    .rdata_o(rd_word)
  );

  // read tag and valid, aligned with the one-cycle memory read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_index_q <= '0;
    end else begin
      rd_valid_q <= rd_accept;
      if (rd_accept) rd_index_q <= rd_addr;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_index = rd_index_q;

  // R9: no valid read result while a capture has been running
  p_no_read_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && $past(capturing)) |-> !rd_valid);

  // R8: the returned index is the address that was requested
  p_read_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_index == $past(rd_addr)));

  // R5: in state mode a static external clock writes nothing
  p_state_no_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STATE && !ext_rise) |-> !we);

endmodule

// File: tb/la_capture_test.sv
module la_capture_test;

  localparam int DEPTH = 16;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          mode_state;
  logic          ext_clk;
  logic [15:0]   probe_in;
  logic          arm;
  logic          host_release;
  logic          capturing;
  logic          done;
  logic          rd_en;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [AW-1:0] rd_index;
  logic [15:0]   rd_word;

  int  tests  = 0;
  int  failed = 0;
  int  cyc    = 0;
  bit  pat_on = 0;
  bit  finished = 0;
  logic [15:0] salt = 16'h5A5A;

  always #2 clk = ~clk;

  la_capture #(.CH_W(16), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .mode_state(mode_state), .ext_clk(ext_clk),
    .probe_in(probe_in), .arm(arm), .host_release(host_release),
    .capturing(capturing), .done(done), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_index(rd_index), .rd_word(rd_word)
  );

  function automatic logic [15:0] pat(int c);
    return 16'(c * 32'h1F3) ^ salt;
  endfunction

  function automatic logic [15:0] sv_val(int j);
    return 16'(j * 32'h1111) ^ 16'hC0DE;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (pat_on) probe_in = pat(cyc);
  endtask

  task automatic read_chk(string req, int a, logic [15:0] exp);
    rd_en   = 1'b1;
    rd_addr = AW'(a);
    step();
    rd_en = 1'b0;
    chk({req, " valid"}, 32'(rd_valid), 32'd1);
    chk({req, " index"}, 32'(rd_index), 32'(a));
    chk({req, " word"},  32'(rd_word),  32'(exp));
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  endtask

  // timing-mode capture, then readback of every address
  task automatic run_timing(logic [15:0] s);
    int c0;
    salt   = s;
    pat_on = 1;
    step();
    c0  = cyc;
    arm = 1'b1;
    step();
    arm = 1'b0;
    chk("R2 capturing after arm", 32'(capturing), 32'd1);
    chk("R2 done cleared by arm", 32'(done), 32'd0);
    for (int s2 = c0 + 2; s2 <= c0 + DEPTH; s2++) begin
      step();
      if (cyc == c0 + 3) begin
        rd_en   = 1'b1;
        rd_addr = AW'(2);
      end
      if (cyc == c0 + 4) begin
        rd_en = 1'b0;
        chk("R9 read during capture", 32'(rd_valid), 32'd0);
      end
    end
    chk("R6 done not yet", 32'(done), 32'd0);
    step();
    chk("R6 done on time", 32'(done), 32'd1);
    chk("R6 capturing off", 32'(capturing), 32'd0);
    for (int k = 0; k < 10; k++) begin
      ext_clk = ~ext_clk;
      step();
    end
    ext_clk = 1'b0;
    for (int i = 0; i < DEPTH; i++) read_chk("R3 R7 R8 timing word", i, pat(c0 + i));
    pat_on = 0;
  endtask

  initial begin
    rst_n = 1'b0; mode_state = 1'b0; ext_clk = 1'b0; probe_in = '0;
    arm = 1'b0; host_release = 1'b0; rd_en = 1'b0; rd_addr = '0;
    repeat (3) @(negedge clk);
    chk("R1 capturing", 32'(capturing), 32'd0);
    chk("R1 done", 32'(done), 32'd0);
    chk("R1 rd_valid", 32'(rd_valid), 32'd0);
    rst_n = 1'b1;
    step();

    run_timing(16'h5A5A);

    // state mode: arm is ignored while held, accepted after release
    mode_state = 1'b1;
    probe_in   = 16'h1234;
    arm = 1'b1; step(); arm = 1'b0; step(); step();
    chk("R10 arm ignored capturing", 32'(capturing), 32'd0);
    chk("R10 arm ignored done", 32'(done), 32'd1);
    host_release = 1'b1; step(); host_release = 1'b0; step();
    arm = 1'b1; step(); arm = 1'b0;
    chk("R10 arm after release", 32'(capturing), 32'd1);
    for (int k = 0; k < 6; k++) step();
    chk("R5 no edges done", 32'(done), 32'd0);
    chk("R5 no edges capturing", 32'(capturing), 32'd1);
    for (int j = 0; j < DEPTH; j++) begin
      probe_in = sv_val(j);
      ext_clk  = 1'b1;
      for (int k = 0; k < 4; k++) step();
      ext_clk  = 1'b0;
      probe_in = ~sv_val(j);
      for (int k = 0; k < 4; k++) step();
      if (j == DEPTH - 2) chk("R6 state not full early", 32'(done), 32'd0);
    end
    chk("R4 state done", 32'(done), 32'd1);
    chk("R4 state capturing off", 32'(capturing), 32'd0);
    for (int i = 0; i < DEPTH; i++) read_chk("R4 R8 state word", i, sv_val(i));

    // arm without release once more: buffer must stay intact
    arm = 1'b1; step(); arm = 1'b0; probe_in = 16'hFFFF; step(); step();
    chk("R10 held done", 32'(done), 32'd1);
    read_chk("R10 R7 held word", 3, sv_val(3));

    host_release = 1'b1; step(); host_release = 1'b0;
    mode_state = 1'b0;
    step();
    run_timing(16'h0F0F);

    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    failed++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

endmodule